// File: doc/BRIEF.md
# Cascadable Two-Channel Compare Timer

This block holds two up-counting timer channels of `W` bits each (8 by default). Each channel advances on a count tick while it runs. When a tick arrives and the count equals the channel's compare value, the channel raises a one-cycle interrupt pulse and toggles its output pin. On that same tick the count goes back to zero instead of incrementing. In continuous mode the channel then runs on. In one-shot mode it stops at that match.

A channel is started by a software start pulse, or by a rising edge on its external trigger input when trigger start is enabled. It is stopped by a software stop pulse, or by a falling edge on the trigger when trigger stop is enabled. Each channel takes its ticks either from the internal tick enable or from rising edges of an external clock pin. That pin is synchronized to the system clock and counted at most once per system clock.

With the cascade input set, the two channels form one `2W`-bit timer. In this mode only channel 0's controls are used. The upper half counts when the lower half wraps. A match needs the whole `2W`-bit count to equal `{cmp_hi, cmp_lo}`, and the result is reported on channel 1's interrupt and output pin.

Top module: `timer_pair`

## Requirements
- R1: After reset, both counts, both output pins, both interrupt pulses and both running flags are 0.
- R2: A running channel counts only on a selected tick; a stopped channel holds its count. With `ext_sel[i]`=0 the tick is `tick_in`; with `ext_sel[i]`=1 it is a rising edge of `ext_clk`, seen through a two-stage synchronizer. The count changes on the third clock edge after `ext_clk` rises, once per rising edge however long the pin stays high, and `tick_in` is ignored.
- R3: In split mode, a tick that arrives while the count equals the compare value sets the count to 0 instead of incrementing it. `irq[i]` is then high for exactly the following cycle, so the period is compare+1 ticks.
- R4: `tout[i]` inverts on every match of its channel.
- R5: With `oneshot[i]`=0 the channel keeps running after a match.
- R6: With `oneshot[i]`=1 the match tick clears `running[i]`, and later ticks leave the count at 0.
- R7: A `sw_start[i]` pulse sets `running[i]` on the next edge. A `sw_stop[i]` pulse clears `running[i]` and `tout[i]` but keeps the count. Stop wins over start in the same cycle.
- R8: With `trig_start_en[i]`=1, a rising edge of `trig_in[i]` starts the channel. `running[i]` goes high on the third clock edge after the input rises.
- R9: With `trig_stop_en[i]`=1, a falling edge of `trig_in[i]` stops the channel. With it 0, a falling edge has no effect.
- R10: In cascade mode `cnt_lo` increments on every tick, and `cnt_hi` increments only on a tick where `cnt_lo` is all ones.
- R11: In cascade mode, a tick while `{cnt_hi,cnt_lo}` equals `{cmp_hi,cmp_lo}` clears both halves, pulses `irq[1]` and toggles `tout[1]`. Channel 0's start, stop, mode and clock-select controls govern the pair.
- R12: In cascade mode `irq[0]` never fires, `running[1]` stays 0, and channel 1's start controls are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Internal count tick enable |
| ext_clk | input | 1 | External count clock pin (asynchronous) |
| trig_in | input | 2 | External trigger per channel (asynchronous) |
| cascade | input | 1 | 1 joins the channels into one 2W-bit timer |
| sw_start | input | 2 | Software start pulse per channel |
| sw_stop | input | 2 | Software stop pulse per channel |
| oneshot | input | 2 | 1 selects one-shot mode, 0 continuous |
| ext_sel | input | 2 | 1 selects ext_clk edges as the tick |
| trig_start_en | input | 2 | Trigger rising edge starts the channel |
| trig_stop_en | input | 2 | Trigger falling edge stops the channel |
| cmp_lo | input | W | Compare value, channel 0 / low half |
| cmp_hi | input | W | Compare value, channel 1 / high half |
| cnt_lo | output | W | Count, channel 0 / low half |
| cnt_hi | output | W | Count, channel 1 / high half |
| irq | output | 2 | One-cycle match interrupt per channel |
| tout | output | 2 | Toggle output pin per channel |
| running | output | 2 | Run state per channel |

## Verification
A corrupted count or a wrong compare decision shows up on the counter outputs at the next tick. It also shifts every later interrupt, so a miscounted interrupt total or a wrong output pin level exposes it within one compare period. A wrong run state shows on `running` one edge after the start or stop event, or two edges later for trigger-driven changes because of the synchronizer. A carry error between the halves in cascade mode shows as a wrong `cnt_hi` at the first wrap of the low half. Random tick patterns against both channels at once, checked at the ports, catch drift between the counters and the interrupt and pin activity.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        TMR_CONT    = 1'b0,
        TMR_ONESHOT = 1'b1
    } tmr_mode_e;

    function automatic logic stops_on_match(tmr_mode_e m);
        return m == TMR_ONESHOT;
    endfunction
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];

    // R2
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    // R9
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));
endmodule

// File: rtl/tmr_run_ctl.sv
module tmr_run_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic done,
    output logic run
);
    typedef struct packed {
        logic run;
    } run_st_t;

    run_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stop || done)  st_d.run = 1'b0;
        else if (start)    st_d.run = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run = st_q.run;

    // R7
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !run);
    // R7
    start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop && !done) |=> run);
    // R6
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !run);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    input  logic         toggle,
    input  logic         irq_set,
    input  logic         out_clr,
    output logic [W-1:0] cnt,
    output logic         tout,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         tout;
        logic         irq;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = irq_set;
        if (clr)      st_d.cnt = '0;
        else if (inc) st_d.cnt = st_q.cnt + W'(1);
        if (out_clr)     st_d.tout = 1'b0;
        else if (toggle) st_d.tout = ~st_q.tout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign tout = st_q.tout;
    assign irq  = st_q.irq;

    // R3
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);
    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> cnt == $past(cnt) + W'(1));
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(cnt));
    // R3
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> irq);
    // R4
    tout_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle && !out_clr) |=> tout != $past(tout));
    // R7
    tout_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_clr |=> !tout);
endmodule

// File: rtl/timer_pair.sv
module timer_pair #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_in,
    input  logic         ext_clk,
    input  logic [1:0]   trig_in,
    input  logic         cascade,
    input  logic [1:0]   sw_start,
    input  logic [1:0]   sw_stop,
    input  logic [1:0]   oneshot,
    input  logic [1:0]   ext_sel,
    input  logic [1:0]   trig_start_en,
    input  logic [1:0]   trig_stop_en,
    input  logic [W-1:0] cmp_lo,
    input  logic [W-1:0] cmp_hi,
    output logic [W-1:0] cnt_lo,
    output logic [W-1:0] cnt_hi,
    output logic [1:0]   irq,
    output logic [1:0]   tout,
    output logic [1:0]   running
);
    import tmr_pkg::*;

    localparam int NCH = 2;
    localparam logic [W-1:0] CNT_MAX = '1;

    logic         ext_rise, ext_fall_unused;
    logic [1:0]   trg_rise, trg_fall;
    logic [1:0]   run;
    logic [1:0]   tick, hit;
    logic         hit16;
    logic [1:0]   start_c, stop_c, done_c;
    logic [1:0]   inc_c, clr_c, tog_c, irq_c, oclr_c;
    logic [W-1:0] cnt [NCH];
    logic [W-1:0] cmp [NCH];
    tmr_mode_e    mode [NCH];

    assign cmp[0] = cmp_lo;
    assign cmp[1] = cmp_hi;

    tmr_sync_edge #(.STAGES(STAGES)) u_ext (
        .clk(clk), .rst_n(rst_n), .din(ext_clk),
        .rise(ext_rise), .fall(ext_fall_unused)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_sync_edge #(.STAGES(STAGES)) u_trg (
            .clk(clk), .rst_n(rst_n), .din(trig_in[i]),
            .rise(trg_rise[i]), .fall(trg_fall[i])
        );

        tmr_run_ctl u_run (
            .clk(clk), .rst_n(rst_n),
            .start(start_c[i]), .stop(stop_c[i]), .done(done_c[i]),
            .run(run[i])
        );

        tmr_chan #(.W(W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .inc(inc_c[i]), .clr(clr_c[i]), .toggle(tog_c[i]),
            .irq_set(irq_c[i]), .out_clr(oclr_c[i]),
            .cnt(cnt[i]), .tout(tout[i]), .irq(irq[i])
        );

        always_comb begin
            mode[i] = tmr_mode_e'(oneshot[i]);
            tick[i] = run[i] & (ext_sel[i] ? ext_rise : tick_in);
            hit[i]  = tick[i] & (cnt[i] == cmp[i]);
        end
    end

    always_comb begin
        hit16 = tick[0] & (cnt[0] == cmp[0]) & (cnt[1] == cmp[1]);

        start_c[0] = sw_start[0] | (trig_start_en[0] & trg_rise[0]);
        stop_c[0]  = sw_stop[0]  | (trig_stop_en[0]  & trg_fall[0]);
        start_c[1] = ~cascade & (sw_start[1] | (trig_start_en[1] & trg_rise[1]));
        stop_c[1]  = cascade | sw_stop[1] | (trig_stop_en[1] & trg_fall[1]);

        if (cascade) begin
            done_c[0] = stops_on_match(mode[0]) & hit16;
            done_c[1] = 1'b0;
            inc_c[0]  = tick[0] & ~hit16;
            inc_c[1]  = tick[0] & ~hit16 & (cnt[0] == CNT_MAX);
            clr_c     = {hit16, hit16};
            tog_c     = {hit16, 1'b0};
            irq_c     = {hit16, 1'b0};
            oclr_c    = {sw_stop[0], sw_stop[0]};
        end else begin
            done_c[0] = stops_on_match(mode[0]) & hit[0];
            done_c[1] = stops_on_match(mode[1]) & hit[1];
            inc_c     = tick & ~hit;
            clr_c     = hit;
            tog_c     = hit;
            irq_c     = hit;
            oclr_c    = sw_stop;
        end
    end

    assign cnt_lo  = cnt[0];
    assign cnt_hi  = cnt[1];
    assign running = run;

    // R12
    lo_irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cascade |=> !irq[0]);
    // R12
    hi_run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cascade |=> !running[1]);
    // R10
    hi_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade && !hit16 && !(tick[0] && cnt_lo == CNT_MAX)) |=> $stable(cnt_hi));
    // R2
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cascade && !running[0]) |=> $stable(cnt_lo));
endmodule

// File: tb/tb_timer_pair.sv
`timescale 1ns/1ps
module tb_timer_pair;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_in = 1'b0, ext_clk = 1'b0, cascade = 1'b0;
    logic [1:0]   trig_in = '0, sw_start = '0, sw_stop = '0, oneshot = '0;
    logic [1:0]   ext_sel = '0, trig_start_en = '0, trig_stop_en = '0;
    logic [W-1:0] cmp_lo = '0, cmp_hi = '0;
    logic [W-1:0] cnt_lo, cnt_hi;
    logic [1:0]   irq, tout, running;

    int errors = 0, checks = 0;
    int irq_seen0 = 0, irq_seen1 = 0;
    bit finished = 0;

    timer_pair #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .ext_clk(ext_clk),
        .trig_in(trig_in), .cascade(cascade), .sw_start(sw_start),
        .sw_stop(sw_stop), .oneshot(oneshot), .ext_sel(ext_sel),
        .trig_start_en(trig_start_en), .trig_stop_en(trig_stop_en),
        .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .irq(irq), .tout(tout), .running(running)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (!rst_n) begin
            irq_seen0 <= 0;
            irq_seen1 <= 0;
        end else begin
            irq_seen0 <= irq_seen0 + int'(irq[0]);
            irq_seen1 <= irq_seen1 + int'(irq[1]);
        end
    end

    function automatic int exp_cnt(int ticks, int cmpv);
        return ticks % (cmpv + 1);
    endfunction

    function automatic int exp_irqs(int ticks, int cmpv);
        return ticks / (cmpv + 1);
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick_in = 0; ext_clk = 0; cascade = 0; trig_in = '0;
        sw_start = '0; sw_stop = '0; oneshot = '0; ext_sel = '0;
        trig_start_en = '0; trig_stop_en = '0; cmp_lo = '0; cmp_hi = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start(logic [1:0] m);
        sw_start = m; @(negedge clk); sw_start = '0;
    endtask

    task automatic pulse_stop(logic [1:0] m);
        sw_stop = m; @(negedge clk); sw_stop = '0;
    endtask

    task automatic give_ticks(int n);
        for (int k = 0; k < n; k++) begin
            tick_in = 1'b1; @(negedge clk);
        end
        tick_in = 1'b0;
    endtask

    initial begin
        int ticks, c0, c1;
        void'($urandom(32'd4242));

        do_reset();
        // R1 reset state
        chk(cnt_lo == 0 && cnt_hi == 0, "R1 counts", int'({cnt_hi, cnt_lo}), 0);
        chk(tout == 0 && irq == 0 && running == 0, "R1 flags",
            int'({tout, irq, running}), 0);

        // R3 R4 R5 continuous, compare 5, 20 ticks
        cmp_lo = 8'd5;
        pulse_start(2'b01);
        give_ticks(20);
        chk(cnt_lo == 8'(exp_cnt(20, 5)), "R3 count", cnt_lo, exp_cnt(20, 5));
        chk(irq_seen0 == exp_irqs(20, 5), "R3 irq pulses", irq_seen0, exp_irqs(20, 5));
        chk(tout[0] == 1'b1, "R4 pin", tout[0], 1);
        chk(running[0] == 1'b1, "R5 still running", running[0], 1);
        chk(cnt_hi == 0 && irq_seen1 == 0, "R2 idle channel holds", cnt_hi, 0);

        // R6 one-shot
        do_reset();
        cmp_lo = 8'd3; oneshot = 2'b01;
        pulse_start(2'b01);
        give_ticks(10);
        chk(running[0] == 1'b0, "R6 stopped", running[0], 0);
        chk(cnt_lo == 0, "R6 count at zero", cnt_lo, 0);
        chk(irq_seen0 == 1, "R6 single irq", irq_seen0, 1);

        // R7 software stop keeps count, clears pin; later ticks ignored
        do_reset();
        cmp_lo = 8'd4;
        pulse_start(2'b01);
        give_ticks(7);
        chk(tout[0] == 1'b1 && cnt_lo == 2, "R7 before stop", cnt_lo, 2);
        pulse_stop(2'b01);
        chk(running[0] == 0 && tout[0] == 0, "R7 stop clears", int'({running[0], tout[0]}), 0);
        give_ticks(5);
        chk(cnt_lo == 2, "R7 count held", cnt_lo, 2);
        sw_start = 2'b01; sw_stop = 2'b01; @(negedge clk);
        sw_start = '0; sw_stop = '0;
        chk(running[0] == 0, "R7 stop wins", running[0], 1'b0);

        // R8 trigger start latency, R9 falling edge
        do_reset();
        cmp_lo = 8'd200; trig_start_en = 2'b01;
        trig_in[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(running[0] == 0, "R8 not yet", running[0], 0);
        @(negedge clk);
        chk(running[0] == 1, "R8 trigger start", running[0], 1);
        trig_in[0] = 1'b0;
        repeat (5) @(negedge clk);
        chk(running[0] == 1, "R9 fall ignored", running[0], 1);
        trig_stop_en = 2'b01; trig_in[0] = 1'b1;
        repeat (5) @(negedge clk);
        trig_in[0] = 1'b0;
        repeat (5) @(negedge clk);
        chk(running[0] == 0, "R9 fall stops", running[0], 0);

        // R2 external clock, tick_in ignored
        do_reset();
        cmp_lo = 8'd200; ext_sel = 2'b01;
        pulse_start(2'b01);
        tick_in = 1'b1;
        for (int p = 0; p < 7; p++) begin
            ext_clk = 1'b1; repeat (4) @(negedge clk);
            ext_clk = 1'b0; repeat (4) @(negedge clk);
        end
        tick_in = 1'b0;
        chk(cnt_lo == 7, "R2 ext edges", cnt_lo, 7);
        ext_clk = 1'b1; @(negedge clk); @(negedge clk);
        chk(cnt_lo == 7, "R2 ext latency", cnt_lo, 7);
        @(negedge clk);
        chk(cnt_lo == 8, "R2 ext third edge", cnt_lo, 8);

        // R10 carry into the upper half
        do_reset();
        cascade = 1'b1; cmp_lo = 8'hFF; cmp_hi = 8'hFF;
        pulse_start(2'b01);
        give_ticks(259);
        chk(cnt_hi == 1 && cnt_lo == 3, "R10 carry", int'({cnt_hi, cnt_lo}), 259);

        // R11 R12 16-bit match
        do_reset();
        cascade = 1'b1; cmp_lo = 8'h05; cmp_hi = 8'h01;
        pulse_start(2'b01);
        pulse_start(2'b10);
        give_ticks(300);
        chk({cnt_hi, cnt_lo} == 16'd38, "R11 16-bit wrap", int'({cnt_hi, cnt_lo}), 38);
        chk(irq_seen1 == 1 && tout[1] == 1, "R11 irq and pin", irq_seen1, 1);
        chk(irq_seen0 == 0 && tout[0] == 0, "R12 low channel quiet", irq_seen0, 0);
        chk(running == 2'b01, "R12 running flags", int'(running), 1);

        // R3 R4 random ticks on both channels
        for (int it = 0; it < 8; it++) begin
            do_reset();
            c0 = 1 + int'($urandom % 40);
            c1 = 1 + int'($urandom % 40);
            cmp_lo = 8'(c0); cmp_hi = 8'(c1);
            pulse_start(2'b11);
            ticks = 0;
            for (int k = 0; k < 120; k++) begin
                tick_in = 1'($urandom % 2);
                ticks += int'(tick_in);
                @(negedge clk);
            end
            tick_in = 1'b0;
            chk(cnt_lo == 8'(exp_cnt(ticks, c0)), "R3 random ch0", cnt_lo, exp_cnt(ticks, c0));
            chk(cnt_hi == 8'(exp_cnt(ticks, c1)), "R3 random ch1", cnt_hi, exp_cnt(ticks, c1));
            chk(irq_seen0 == exp_irqs(ticks, c0), "R3 random irq0", irq_seen0, exp_irqs(ticks, c0));
            chk(irq_seen1 == exp_irqs(ticks, c1), "R3 random irq1", irq_seen1, exp_irqs(ticks, c1));
            chk(tout[0] == 1'(exp_irqs(ticks, c0)), "R4 random pin0", tout[0], exp_irqs(ticks, c0) % 2);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule